// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is an SPI slave that fronts a byte-wide nonvolatile-style memory, here modelled as a synthesizable register array that comes out of reset filled with 0xFF. A host selects the block with an active-low chip select. It shifts in a one-byte command, an optional address byte and optional data bytes, most significant bit first. The block works in SPI modes 0 and 3. It reads the serial input on rising serial clock edges and changes its serial output after falling edges. Serial clock, chip select, data input and write-protect are all oversampled by a faster system clock through two-flop synchronizers, and every edge is found in that clock domain.

Reads stream bytes from any start address and run on past the top address back to zero for as long as chip select stays low. Writes collect up to one page of bytes in a page buffer. Once chip select has risen cleanly on a byte boundary, a self-timed busy period starts whose length is a count of system clocks. At the end of that period the received bytes are written to the array and the write-enable latch drops. A two-bit protection field in the status byte locks an upper quarter, the upper half, or the whole array against writes.

The command state machine has these states: ST_IDLE (deselected), ST_OPCODE (collecting the command byte), ST_ADDR (collecting the address byte), ST_RDATA (streaming array data), ST_SRDATA (streaming the status byte), ST_WDATA (collecting page data), ST_WSR (collecting the new status byte), ST_WAIT (command complete, waiting for deselect) and ST_IGNORE (frame discarded until deselect). Its transitions are: a chip select fall takes ST_IDLE to ST_OPCODE, and a chip select rise takes any other state back to ST_IDLE. In ST_OPCODE, a complete command byte goes to ST_WAIT (set or clear enable), ST_SRDATA (status read), ST_WSR (status write), ST_ADDR (array read or write) or ST_IGNORE (unknown code, or array and status-write commands issued while busy). A complete address byte goes to ST_RDATA or ST_WDATA. A complete status byte goes from ST_WSR to ST_WAIT. Any further rising serial clock in ST_WAIT goes to ST_IGNORE.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset the status byte reads 0xF0 and miso_en is low. The status byte is laid out as {1111, prot[1:0], wel, wip}, with wel at bit 1 and wip at bit 0.
- R2: Command 0x06 (bit 3 don't care) sets wel and command 0x04 clears it, each taking effect when chip select rises. A command byte is valid only if its upper four bits are zero.
- R3: Command 0000 a8 011 followed by an address byte starts a read at {a8, address}. Data leaves MSB first, with the first bit driven after the falling edge that follows the last address bit. The address increments per byte and rolls from 0x1FF to 0x000. Status reads (command 0x05) work in both mode 0 and mode 3.
- R4: Command 0000 a8 010, an address byte and data bytes buffer data inside the addressed 16-byte page. Bytes beyond the page end wrap to the page start and overwrite earlier buffered bytes. Only bytes that were received are committed, and the other bytes of the page keep their values.
- R5: A write or status write is accepted only when chip select rises after a whole number of data bytes. Any partial byte discards the command, with no busy period, no change to the array, and wel left unchanged.
- R6: A write or status write is rejected when wel is 0 or wp_n is low. A rejected command leaves the array, the protection bits and wel unchanged.
- R7: A write to a protected page is rejected. prot=01 protects 0x180-0x1FF, prot=10 protects 0x100-0x1FF, and prot=11 protects the whole array.
- R8: An accepted write sets wip for WCYC system clocks. During that time, status reads work and show the old protection bits, while read, write and status-write commands are ignored and miso_en stays low. When the period ends, wip and wel both read 0.
- R9: Command 0x01 with a data byte updates only prot from data bits 3:2, at the end of the busy period. Bits 7:4 always read as 1.
- R10: An unknown command, or one with nonzero upper bits, makes the rest of the frame ignored: miso_en stays low and no state changes.
- R11: miso_en is low whenever chip select has been high for more than two system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Active-low write protect |
| miso | output | 1 | Serial data out, 0 when not enabled |
| miso_en | output | 1 | Output enable for the serial data pad (low means high impedance) |

## Verification
The bench builds the block with the default nine-bit address and 16-byte page, and sets WCYC to 1000 system clocks. At that length the busy period outlasts the command byte of a follow-on frame, so a read and a write issued during the busy period are really exercised. With a serial half period of eight system clocks, the synchronizer and edge-detector delays settle well inside each bit.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPCODE, ST_ADDR, ST_RDATA, ST_SRDATA,
        ST_WDATA, ST_WSR, ST_WAIT, ST_IGNORE
    } fsm_t;

    typedef enum logic [1:0] {PD_NONE, PD_SETWE, PD_CLRWE, PD_WRSTAT} pend_t;

    localparam logic [2:0] CMD_SETWE  = 3'b110;
    localparam logic [2:0] CMD_CLRWE  = 3'b100;
    localparam logic [2:0] CMD_RDSTAT = 3'b101;
    localparam logic [2:0] CMD_WRSTAT = 3'b001;
    localparam logic [2:0] CMD_READ   = 3'b011;
    localparam logic [2:0] CMD_WRITE  = 3'b010;

    // protection decode on the two top address bits of the page
    function automatic logic lock_hit(input logic [1:0] prot, input logic [1:0] hi);
        unique case (prot)
            2'b00:   lock_hit = 1'b0;
            2'b01:   lock_hit = (hi == 2'b11);
            2'b10:   lock_hit = hi[1];
            default: lock_hit = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
    parameter int unsigned     W    = 4,
    parameter logic [W-1:0]    INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= INIT[b];
                s2 <= INIT[b];
            end else begin
                s1 <= d[b];
                s2 <= s1;
            end
        end
        assign q[b] = s2;
    end
endmodule

// File: rtl/spi_ee_pagebuf.sv
module spi_ee_pagebuf #(
    parameter int unsigned PAGE_W = 4,
    localparam int unsigned PAGE_N = 1 << PAGE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  we,
    input  logic [PAGE_W-1:0]     woff,
    input  logic [7:0]            wdata,
    output logic [8*PAGE_N-1:0]   data,
    output logic [PAGE_N-1:0]     valid
);
    for (genvar e = 0; e < PAGE_N; e++) begin : g_ent
        logic [7:0] ent;
        logic       v;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent <= '0;
                v   <= 1'b0;
            end else if (clr) begin
                v   <= 1'b0;
            end else if (we && woff == PAGE_W'(e)) begin
                ent <= wdata;
                v   <= 1'b1;
            end
        end
        assign data[8*e +: 8] = ent;
        assign valid[e]       = v;
    end
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned PAGE_W = 4,
    localparam int unsigned DEPTH  = 1 << ADDR_W,
    localparam int unsigned PAGE_N = 1 << PAGE_W,
    localparam int unsigned PG_W   = ADDR_W - PAGE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [7:0]          rdata,
    input  logic                commit,
    input  logic [PG_W-1:0]     cpage,
    input  logic [8*PAGE_N-1:0] cdata,
    input  logic [PAGE_N-1:0]   cvalid
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= 8'hFF;
        end else if (commit) begin
            for (int w = 0; w < DEPTH; w++) begin
                if ((w >> PAGE_W) == int'(cpage) && cvalid[w % PAGE_N])
                    mem[w] <= cdata[8*(w % PAGE_N) +: 8];
            end
        end
    end

    assign rdata = mem[raddr];

    AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cvalid != '0)); // R4
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
    import spi_ee_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned PAGE_W = 4,
    parameter int unsigned WCYC   = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    input  logic wp_n,
    output logic miso,
    output logic miso_en
);
    localparam int unsigned PAGE_N = 1 << PAGE_W;
    localparam int unsigned PG_W   = ADDR_W - PAGE_W;
    localparam int unsigned TMR_W  = $clog2(WCYC + 1);

    // ---------------- input synchronizers and edge detect
    logic [3:0] syn;
    logic       sck_s, cs_s, mosi_s, wp_s, sck_d, cs_d;
    logic       sck_rise, sck_fall, cs_rise, cs_fall;

    spi_ee_sync #(.W(4), .INIT(4'b1010)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({wp_n, mosi, cs_n, sck}), .q(syn));

    assign sck_s  = syn[0];
    assign cs_s   = syn[1];
    assign mosi_s = syn[2];
    assign wp_s   = syn[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign cs_rise  = cs_s & ~cs_d;
    assign cs_fall  = ~cs_s & cs_d;

    // ---------------- state and datapath registers
    fsm_t                state, nxt;
    pend_t               pend;
    logic [6:0]          ish;
    logic [2:0]          icnt, ocnt;
    logic [7:0]          in_byte;
    logic                byte_done;
    logic                op_a8, is_write, got_byte;
    logic [ADDR_W-1:0]   addr;
    logic [PAGE_W-1:0]   woff;
    logic [1:0]          sr_new, prot;
    logic                wel, wip, page_go, sr_go;
    logic [TMR_W-1:0]    tmr;
    logic [8:0]          full_addr;
    logic [6:0]          osh;
    logic                miso_q;
    logic [7:0]          mem_rdata, status;
    logic [8*PAGE_N-1:0] buf_data;
    logic [PAGE_N-1:0]   buf_valid;
    logic                buf_clr, buf_we, busy_end, commit;
    logic                accept_page, accept_sr, locked;

    assign in_byte   = {ish, mosi_s};
    assign byte_done = sck_rise && (icnt == 3'd7);
    assign full_addr = {op_a8, in_byte};
    assign status    = {4'hF, prot, wel, wip};
    assign locked    = lock_hit(prot, addr[ADDR_W-1 -: 2]);

    // ---------------- state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // ---------------- next state
    always_comb begin
        nxt = state;
        if (state != ST_IDLE && cs_rise) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (cs_fall) nxt = ST_OPCODE;
                ST_OPCODE: if (byte_done) begin
                    if (in_byte[7:4] != 4'h0) nxt = ST_IGNORE;
                    else begin
                        case (in_byte[2:0])
                            CMD_SETWE, CMD_CLRWE: nxt = ST_WAIT;
                            CMD_RDSTAT:           nxt = ST_SRDATA;
                            CMD_WRSTAT:           nxt = wip ? ST_IGNORE : ST_WSR;
                            CMD_READ, CMD_WRITE:  nxt = wip ? ST_IGNORE : ST_ADDR;
                            default:              nxt = ST_IGNORE;
                        endcase
                    end
                end
                ST_ADDR:   if (byte_done) nxt = is_write ? ST_WDATA : ST_RDATA;
                ST_WSR:    if (byte_done) nxt = ST_WAIT;
                ST_WAIT:   if (sck_rise)  nxt = ST_IGNORE;
                ST_RDATA, ST_SRDATA, ST_WDATA, ST_IGNORE: nxt = state;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // ---------------- input shifter and command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ish <= '0; icnt <= '0; op_a8 <= 1'b0; is_write <= 1'b0;
            addr <= '0; woff <= '0; got_byte <= 1'b0; pend <= PD_NONE;
            sr_new <= '0;
        end else begin
            if (cs_fall) begin
                icnt <= '0;
                pend <= PD_NONE;
            end else if (state != ST_IDLE && sck_rise) begin
                ish  <= in_byte[6:0];
                icnt <= icnt + 3'd1;
            end
            if (state == ST_OPCODE && byte_done) begin
                op_a8    <= in_byte[3];
                is_write <= (in_byte[2:0] == CMD_WRITE);
                unique case (in_byte[2:0])
                    CMD_SETWE:  pend <= PD_SETWE;
                    CMD_CLRWE:  pend <= PD_CLRWE;
                    CMD_WRSTAT: pend <= PD_WRSTAT;
                    default:    pend <= PD_NONE;
                endcase
            end
            if (state == ST_ADDR && byte_done) begin
                addr     <= full_addr[ADDR_W-1:0];
                woff     <= full_addr[PAGE_W-1:0];
                got_byte <= 1'b0;
            end
            if (state == ST_WDATA && byte_done) begin
                woff     <= woff + 1'b1;
                got_byte <= 1'b1;
            end
            if (state == ST_WSR && byte_done) sr_new <= in_byte[3:2];
            if (state == ST_RDATA && sck_fall && ocnt == 3'd0) addr <= addr + 1'b1;
        end
    end

    // ---------------- acceptance, busy timer and status bits
    assign accept_page = (state == ST_WDATA) && cs_rise && (icnt == 3'd0) && got_byte
                         && wel && wp_s && !wip && !locked;
    assign accept_sr   = (state == ST_WAIT) && cs_rise && (pend == PD_WRSTAT)
                         && wel && wp_s && !wip;
    assign busy_end    = wip && (tmr == TMR_W'(WCYC - 1));
    assign commit      = busy_end && page_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wip <= 1'b0; wel <= 1'b0; prot <= 2'b00; tmr <= '0;
            page_go <= 1'b0; sr_go <= 1'b0;
        end else begin
            if (busy_end) begin
                wip <= 1'b0; wel <= 1'b0; tmr <= '0;
                page_go <= 1'b0; sr_go <= 1'b0;
                if (sr_go) prot <= sr_new;
            end else if (wip) begin
                tmr <= tmr + 1'b1;
            end
            if (accept_page || accept_sr) begin
                wip <= 1'b1; tmr <= '0;
                page_go <= accept_page;
                sr_go   <= accept_sr;
            end
            if (state == ST_WAIT && cs_rise) begin
                if (pend == PD_SETWE) wel <= 1'b1;
                if (pend == PD_CLRWE) wel <= 1'b0;
            end
        end
    end

    // ---------------- page buffer and array
    assign buf_clr = (state == ST_ADDR) && byte_done && is_write;
    assign buf_we  = (state == ST_WDATA) && byte_done;

    spi_ee_pagebuf #(.PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .woff(woff),
        .wdata(in_byte), .data(buf_data), .valid(buf_valid));

    spi_ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .raddr(addr), .rdata(mem_rdata),
        .commit(commit), .cpage(addr[ADDR_W-1 -: PG_W]),
        .cdata(buf_data), .cvalid(buf_valid));

    // ---------------- serial output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso_q <= 1'b0; osh <= '0; ocnt <= '0;
        end else if (cs_fall) begin
            ocnt <= '0;
        end else if (sck_fall && (state == ST_RDATA || state == ST_SRDATA)) begin
            if (ocnt == 3'd0) begin
                miso_q <= (state == ST_RDATA) ? mem_rdata[7]   : status[7];
                osh    <= (state == ST_RDATA) ? mem_rdata[6:0] : status[6:0];
            end else begin
                miso_q <= osh[6];
                osh    <= {osh[5:0], 1'b0};
            end
            ocnt <= ocnt + 3'd1;
        end
    end

    assign miso_en = (state == ST_RDATA) || (state == ST_SRDATA);
    assign miso    = miso_en & miso_q;

    // ---------------- assertions
    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> ($past(wel) && $past(wp_s))); // R6
    AST_WEL_DROPS_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel); // R8
    AST_NO_XFER_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA || state == ST_WDATA || state == ST_WSR) |-> !wip); // R8
    AST_PROT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot) |-> $fell(wip)); // R9
    AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && cs_d) |=> !miso_en); // R11
endmodule

// File: tb/test_spi_eeprom_engine.sv
module test_spi_eeprom_engine;
    localparam int HP   = 8;
    localparam int WCYC = 1000;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
    logic miso, miso_en;
    logic idle_lvl = 1'b0;
    logic watch = 1'b0, saw_en = 1'b0;
    int   n_run = 0, n_fail = 0, cyc = 0;
    logic [7:0] wdat [32];
    logic [7:0] rdat [32];
    logic [7:0] st;

    spi_eeprom_engine #(.ADDR_W(9), .PAGE_W(4), .WCYC(WCYC)) i_spi_eeprom_engine (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .wp_n(wp_n), .miso(miso), .miso_en(miso_en));

    always #4 clk = ~clk;

    // {addr[8:0], data[7:0]} single byte write then read-back vectors
    localparam logic [16:0] VEC [6] = '{
        {9'h000, 8'h11}, {9'h0AB, 8'hC3}, {9'h100, 8'h5A},
        {9'h1FF, 8'hE7}, {9'h07F, 8'h3C}, {9'h0FF, 8'h96}};

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 190000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    always @(negedge clk) if (watch && miso_en) saw_en = 1'b1;

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - nb; i--) begin
            @(negedge clk); sck = 1'b0; mosi = tx[i];
            repeat (HP) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HP - 1) @(negedge clk);
        end
    endtask

    task automatic cs_lo();
        @(negedge clk); cs_n = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (HP / 2) @(negedge clk);
        cs_n = 1'b1;
        repeat (HP) @(negedge clk);
        sck = idle_lvl;
        repeat (3 * HP) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] d;
        cs_lo(); xbits(op, 8, d); cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        cs_lo(); xbits(8'h05, 8, d); xbits(8'h00, 8, s); cs_hi();
    endtask

    task automatic wr(input logic [8:0] a, input int n, input int extra_bits);
        logic [7:0] d;
        cs_lo();
        xbits({4'b0000, a[8], 3'b010}, 8, d);
        xbits(a[7:0], 8, d);
        for (int k = 0; k < n; k++) xbits(wdat[k], 8, d);
        if (extra_bits > 0) xbits(8'hA5, extra_bits, d);
        cs_hi();
    endtask

    task automatic rd(input logic [8:0] a, input int n);
        logic [7:0] d;
        cs_lo();
        xbits({4'b0000, a[8], 3'b011}, 8, d);
        xbits(a[7:0], 8, d);
        for (int k = 0; k < n; k++) xbits(8'h00, 8, rdat[k]);
        cs_hi();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        cs_lo(); xbits(8'h01, 8, d); xbits(v, 8, d); cs_hi();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 40; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic wr1(input logic [8:0] a, input logic [7:0] v);
        cmd(8'h06); wdat[0] = v; wr(a, 1, 0); wait_idle();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 / R11 reset state
        chk({7'b0, miso_en}, 8'h00, "R11 enable low after reset");
        rdsr(st); chk(st, 8'hF0, "R1 status after reset");
        chk({7'b0, miso_en}, 8'h00, "R11 enable low between frames");

        // R2 enable latch
        cmd(8'h06); rdsr(st); chk(st, 8'hF2, "R2 set enable");
        cmd(8'h04); rdsr(st); chk(st, 8'hF0, "R2 clear enable");
        cmd(8'h0E); rdsr(st); chk(st, 8'hF2, "R2 set enable with bit3 set");
        cmd(8'h04);

        // vector table: write then read back, covering a8 on both halves
        for (int v = 0; v < 6; v++) begin
            wr1(VEC[v][16:8], VEC[v][7:0]);
            rd(VEC[v][16:8], 1);
            chk(rdat[0], VEC[v][7:0], "R4 table read-back");
        end
        rdsr(st); chk(st, 8'hF0, "R8 wel cleared after write cycle");

        // R3 rollover past top address
        rd(9'h1FF, 2);
        chk(rdat[0], 8'hE7, "R3 read top address");
        chk(rdat[1], 8'h11, "R3 rollover to zero");

        // R4 page wrap: start at offset 14 of page 0x050
        cmd(8'h06);
        wdat[0] = 8'hA0; wdat[1] = 8'hA1; wdat[2] = 8'hA2; wdat[3] = 8'hA3;
        wr(9'h05E, 4, 0); wait_idle();
        rd(9'h05E, 3);
        chk(rdat[0], 8'hA0, "R4 wrap first byte");
        chk(rdat[1], 8'hA1, "R4 wrap last in page");
        chk(rdat[2], 8'hFF, "R4 next page untouched");
        rd(9'h050, 3);
        chk(rdat[0], 8'hA2, "R4 wrapped to page start");
        chk(rdat[1], 8'hA3, "R4 wrapped second");
        chk(rdat[2], 8'hFF, "R4 unreceived byte kept");

        // R4 seventeen bytes overwrite the first buffered byte
        cmd(8'h06);
        for (int k = 0; k < 17; k++) wdat[k] = 8'hB0 + 8'(k);
        wr(9'h030, 17, 0); wait_idle();
        rd(9'h030, 2);
        chk(rdat[0], 8'hC0, "R4 overwrite by wrapped byte");
        chk(rdat[1], 8'hB1, "R4 second byte intact");
        rd(9'h03F, 1); chk(rdat[0], 8'hBF, "R4 page end byte");

        // R4 partial page keeps neighbour in same page
        wr1(9'h0F0, 8'h44);
        rd(9'h0FF, 1); chk(rdat[0], 8'h96, "R4 neighbour in page kept");

        // R5 partial byte discards the write
        cmd(8'h06); wdat[0] = 8'h12; wr(9'h070, 1, 4);
        rdsr(st); chk(st, 8'hF2, "R5 no busy, wel kept");
        rd(9'h070, 1); chk(rdat[0], 8'hFF, "R5 array unchanged");
        cmd(8'h04);

        // R6 no enable latch
        wdat[0] = 8'h00; wr(9'h0AB, 1, 0);
        rdsr(st); chk(st, 8'hF0, "R6 no busy without wel");
        rd(9'h0AB, 1); chk(rdat[0], 8'hC3, "R6 array unchanged without wel");
        // R6 write protect low
        cmd(8'h06); wp_n = 1'b0; wr(9'h0AB, 1, 0);
        rdsr(st); chk(st, 8'hF2, "R6 wp low: no busy, wel kept");
        wrsr(8'h0C); rdsr(st); chk(st, 8'hF2, "R6 wp low: status write rejected");
        wp_n = 1'b1;
        rd(9'h0AB, 1); chk(rdat[0], 8'hC3, "R6 array unchanged with wp low");
        cmd(8'h04);

        // R9 / R8 status write, frozen prot while busy
        cmd(8'h06); wrsr(8'hF7);
        rdsr(st); chk(st, 8'hF3, "R8 busy status with old prot");
        wait_idle();
        rdsr(st); chk(st, 8'hF4, "R9 prot=01 only bits 3:2 taken");

        // R7 protection levels
        cmd(8'h06); wdat[0] = 8'h22; wr(9'h190, 1, 0);
        rdsr(st); chk(st, 8'hF6, "R7 upper quarter write rejected");
        rd(9'h190, 1); chk(rdat[0], 8'hFF, "R7 upper quarter unchanged");
        wdat[0] = 8'h33; wr(9'h150, 1, 0); wait_idle();
        rd(9'h150, 1); chk(rdat[0], 8'h33, "R7 below quarter accepted");
        cmd(8'h06); wrsr(8'h08); wait_idle();
        cmd(8'h06); wdat[0] = 8'h55; wr(9'h120, 1, 0);
        rd(9'h120, 1); chk(rdat[0], 8'hFF, "R7 upper half rejected");
        cmd(8'h04);
        cmd(8'h06); wrsr(8'h0C); wait_idle();
        cmd(8'h06); wdat[0] = 8'h66; wr(9'h010, 1, 0);
        rd(9'h010, 1); chk(rdat[0], 8'hFF, "R7 whole array rejected");
        cmd(8'h04);
        cmd(8'h06); wrsr(8'h00); wait_idle();
        rdsr(st); chk(st, 8'hF0, "R9 prot cleared");

        // R8 commands ignored while busy
        cmd(8'h06); wdat[0] = 8'h5A; wr(9'h0C0, 1, 0);
        wdat[0] = 8'h77; wr(9'h0C1, 1, 0);
        wait_idle();
        rd(9'h0C1, 1); chk(rdat[0], 8'hFF, "R8 write during busy ignored");
        rd(9'h0C0, 1); chk(rdat[0], 8'h5A, "R8 first write committed");
        cmd(8'h06); wdat[0] = 8'h5B; wr(9'h0C2, 1, 0);
        saw_en = 1'b0; watch = 1'b1;
        rd(9'h0C0, 2);
        watch = 1'b0;
        chk({7'b0, saw_en}, 8'h00, "R8 read during busy gives no output");
        wait_idle();
        rdsr(st); chk(st, 8'hF0, "R8 wip and wel clear at end");

        // R10 unknown opcode
        saw_en = 1'b0; watch = 1'b1;
        begin
            logic [7:0] d;
            cs_lo(); xbits(8'h07, 8, d); xbits(8'h05, 8, d); xbits(8'h00, 8, d); cs_hi();
        end
        watch = 1'b0;
        chk({7'b0, saw_en}, 8'h00, "R10 unknown opcode output quiet");
        cmd(8'h86); rdsr(st); chk(st, 8'hF0, "R10 upper bits set: no effect");

        // R3 mode 3 status read
        idle_lvl = 1'b1; sck = 1'b1;
        repeat (2 * HP) @(negedge clk);
        cmd(8'h06);
        rdsr(st); chk(st, 8'hF2, "R3 mode 3 status read");
        cmd(8'h04);
        rd(9'h0C0, 1); chk(rdat[0], 8'h5A, "R3 mode 3 array read");
        idle_lvl = 1'b0; sck = 1'b0;
        repeat (2 * HP) @(negedge clk);
        chk({7'b0, miso_en}, 8'h00, "R11 enable low at end");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule